// File: doc/BRIEF.md
# Sweep Cycle and Holdoff Sequencer

This block runs the repeated cycle of a swept instrument. A sweep stays active until the ramp logic reports that it has finished. The sequencer then drops the sweep gate and asserts a ramp-discharge control. It also starts a holdoff interval, timed by a counter. The interval is long enough for the ramp to discharge and for the swept circuits to settle. Its length comes from two rate-selection bits, so slower sweeps get a longer rest. When holdoff expires, the block reports that it will accept a trigger. The first rising trigger edge after that point starts the next sweep.

A host can ask for single sweeps. In that mode a trigger is accepted only after an arm strobe, and the arm flag clears when the sweep starts. Each arm command therefore yields exactly one sweep. A host abort strobe ends the current sweep at once and begins a fresh holdoff. When a manual or externally driven sweep is selected, the gate is held active and the discharge control is released for as long as that mode remains selected. Both the trigger and the end-of-sweep inputs are asynchronous. Each passes through a two-flop synchroniser and a rising-edge detector. The arm and abort strobes are single-cycle pulses that are already synchronous to the clock.

Top module: `sweep_seq`

## Requirements
- R1: After reset the sweep gate is low, the discharge output is high and the block is ready for a trigger (trigger-enable high when single-sweep mode is off).
- R2: A rising edge on the trigger input while trigger-enable is high starts a sweep. On the third rising clock edge after the input rises, the gate goes high, discharge goes low and trigger-enable goes low.
- R3: A rising edge on the end-of-sweep input during a sweep ends it after the same three-edge latency. The gate goes low, discharge goes high and holdoff begins.
- R4: Holdoff lasts HOLD_BASE clock cycles. HOLD_EXT0 more are added when rate-select bit 0 is 1, and HOLD_EXT1 more when bit 1 is 1. The selection is taken when holdoff begins. The length is measured from the cycle discharge rises to the cycle trigger-enable rises.
- R5: Trigger edges that occur during holdoff are ignored. They neither shorten holdoff nor start a sweep once holdoff ends.
- R6: A trigger input held high starts at most one sweep. A new sweep needs a new rising edge.
- R7: With single-sweep mode set, trigger-enable stays low and triggers are ignored until an arm strobe is received. Trigger-enable rises the cycle after the strobe.
- R8: The arm flag clears when a sweep starts. In single-sweep mode, the holdoff after that sweep ends with trigger-enable low, and the next trigger is ignored until the block is armed again.
- R9: An abort strobe during a sweep ends it on the next clock edge: the gate goes low and discharge goes high. A full holdoff for the current rate selection follows.
- R10: If an abort strobe and an accepted trigger edge act on the same clock edge, the abort wins. No sweep starts, and holdoff begins.
- R11: While manual/external mode is selected, the gate is high, discharge is low and trigger-enable is low, with no clock delay. End-of-sweep edges are ignored in this mode. On release, a full holdoff follows.
- R12: An end-of-sweep edge while the block is waiting for a trigger has no effect. The gate stays low, and trigger-enable stays high with no new holdoff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sweep_end_i | input | 1 | Asynchronous end-of-sweep indication; rising edge acts |
| trig_i | input | 1 | Asynchronous trigger; rising edge acts |
| single_mode_i | input | 1 | 1 = single-sweep mode |
| manual_mode_i | input | 1 | 1 = manual/external sweep, gate forced active |
| rate_sel_i | input | 2 | Holdoff extension selects (bit 0 adds HOLD_EXT0, bit 1 adds HOLD_EXT1) |
| arm_i | input | 1 | One-cycle host arm strobe for single sweep |
| abort_i | input | 1 | One-cycle host abort strobe |
| sweep_gate_o | output | 1 | High while a sweep runs or manual mode is selected |
| discharge_o | output | 1 | High while the ramp must be held discharged |
| trig_en_o | output | 1 | High when a trigger edge would start a sweep |

## Verification
The bench measures holdoff as a cycle count for all four rate selections, and again after an abort and after a manual-mode release. A design that forgot to reload the counter, or that added the wrong extension, gives a count different from the one queued. The bench fires triggers inside holdoff and holds a trigger high across a whole cycle. A level-sensitive design, or one that remembered an early trigger, would start an extra sweep. In single-sweep mode the bench tries triggers both before arming and after a sweep has used up the arm. It also places an abort on the exact clock edge where a synchronised trigger lands. A design that gave priority to the trigger would raise the gate there.

// File: rtl/sweep_seq_pkg.sv
package sweep_seq_pkg;

  typedef enum logic [1:0] {
    ST_READY  = 2'd0,
    ST_SWEEP  = 2'd1,
    ST_HOLD   = 2'd2,
    ST_MANUAL = 2'd3
  } sweep_state_e;

  // Holdoff length in clock cycles for a given rate selection.
  function automatic int unsigned holdoff_cycles(
    input int unsigned base,
    input int unsigned ext0,
    input int unsigned ext1,
    input logic [1:0]  sel
  );
    int unsigned n;
    n = base;
    if (sel[0]) n = n + ext0;
    if (sel[1]) n = n + ext1;
    return n;
  endfunction

endpackage

// File: rtl/sweep_edge_sync.sv
module sweep_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic rise_o
);

  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  // rise is seen once per input edge
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  assert_single_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/sweep_holdoff_timer.sv
module sweep_holdoff_timer
  import sweep_seq_pkg::*;
#(
  parameter int unsigned HOLD_BASE = 16,
  parameter int unsigned HOLD_EXT0 = 24,
  parameter int unsigned HOLD_EXT1 = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [1:0] sel_i,
  input  logic       run_i,
  output logic       done_o
);

  localparam int unsigned MAX_LEN = HOLD_BASE + HOLD_EXT0 + HOLD_EXT1;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  int unsigned      len;

  always_comb len = holdoff_cycles(HOLD_BASE, HOLD_EXT0, HOLD_EXT1, sel_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (load_i)                   cnt_q <= CNT_W'(len - 1);
    else if (run_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = run_i && (cnt_q == '0);

  assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_load_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (32'(cnt_q) < MAX_LEN));

endmodule

// File: rtl/sweep_ctrl_fsm.sv
module sweep_ctrl_fsm
  import sweep_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trig_evt_i,
  input  logic end_evt_i,
  input  logic abort_i,
  input  logic arm_i,
  input  logic single_i,
  input  logic manual_i,
  input  logic hold_done_i,
  output logic load_o,
  output logic run_o,
  output logic gate_o,
  output logic discharge_o,
  output logic trig_en_o
);

  sweep_state_e state_q, state_d;
  logic armed_q;
  logic ready_ok;
  logic start_evt;
  logic enter_hold;

  assign ready_ok  = !single_i || armed_q;
  assign trig_en_o = !manual_i && (state_q == ST_READY) && ready_ok;

  always_comb begin
    state_d    = state_q;
    enter_hold = 1'b0;
    start_evt  = 1'b0;
    if (manual_i) begin
      state_d = ST_MANUAL;
    end else if (state_q == ST_MANUAL) begin
      state_d    = ST_HOLD;
      enter_hold = 1'b1;
    end else if (abort_i) begin
      state_d    = ST_HOLD;
      enter_hold = 1'b1;
    end else begin
      unique case (state_q)
        ST_SWEEP: if (end_evt_i) begin
          state_d    = ST_HOLD;
          enter_hold = 1'b1;
        end
        ST_HOLD:  if (hold_done_i) state_d = ST_READY;
        ST_READY: if (trig_evt_i && ready_ok) begin
          state_d   = ST_SWEEP;
          start_evt = 1'b1;
        end
        default:  state_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_READY;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed_q <= 1'b0;
    else if (start_evt) armed_q <= 1'b0;
    else if (arm_i)     armed_q <= 1'b1;
  end

  assign load_o      = enter_hold;
  assign run_o       = (state_q == ST_HOLD);
  assign gate_o      = manual_i || (state_q == ST_SWEEP);
  assign discharge_o = !manual_i && ((state_q == ST_HOLD) || (state_q == ST_READY));

  assert_start_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SWEEP && $past(state_q) == ST_READY) |-> $past(trig_en_o));

  assert_end_to_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (end_evt_i && state_q == ST_SWEEP && !manual_i && !abort_i) |=> (state_q == ST_HOLD));

  assert_hold_blocks_trig_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |-> !trig_en_o);

  assert_needs_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (single_i && !armed_q) |-> !trig_en_o);

  assert_arm_used_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SWEEP && $past(state_q) == ST_READY) |-> !armed_q);

  assert_abort_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && !manual_i) |=> (state_q == ST_HOLD));

  assert_abort_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && trig_evt_i && !manual_i) |=> (state_q != ST_SWEEP));

  assert_manual_forced_R11: assert property (@(posedge clk) disable iff (!rst_n)
    manual_i |-> (gate_o && !discharge_o && !trig_en_o));

endmodule

// File: rtl/sweep_seq.sv
module sweep_seq
  import sweep_seq_pkg::*;
#(
  parameter int unsigned HOLD_BASE   = 16,
  parameter int unsigned HOLD_EXT0   = 24,
  parameter int unsigned HOLD_EXT1   = 48,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sweep_end_i,
  input  logic       trig_i,
  input  logic       single_mode_i,
  input  logic       manual_mode_i,
  input  logic [1:0] rate_sel_i,
  input  logic       arm_i,
  input  logic       abort_i,
  output logic       sweep_gate_o,
  output logic       discharge_o,
  output logic       trig_en_o
);

  logic trig_evt;
  logic end_evt;
  logic hold_load;
  logic hold_run;
  logic hold_done;

  sweep_edge_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (trig_i),
    .rise_o (trig_evt)
  );

  sweep_edge_sync #(.STAGES(SYNC_STAGES)) u_end_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (sweep_end_i),
    .rise_o (end_evt)
  );

  sweep_holdoff_timer #(
    .HOLD_BASE (HOLD_BASE),
    .HOLD_EXT0 (HOLD_EXT0),
    .HOLD_EXT1 (HOLD_EXT1)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (hold_load),
    .sel_i  (rate_sel_i),
    .run_i  (hold_run),
    .done_o (hold_done)
  );

  sweep_ctrl_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_evt_i  (trig_evt),
    .end_evt_i   (end_evt),
    .abort_i     (abort_i),
    .arm_i       (arm_i),
    .single_i    (single_mode_i),
    .manual_i    (manual_mode_i),
    .hold_done_i (hold_done),
    .load_o      (hold_load),
    .run_o       (hold_run),
    .gate_o      (sweep_gate_o),
    .discharge_o (discharge_o),
    .trig_en_o   (trig_en_o)
  );

  assert_gate_vs_discharge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sweep_gate_o && discharge_o));

endmodule

// File: tb/sweep_seq_test.sv
module sweep_seq_test;

  localparam int CLK_P = 10;
  localparam int HB  = 16;
  localparam int HE0 = 24;
  localparam int HE1 = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sweep_end_i = 1'b0, trig_i = 1'b0, single_mode_i = 1'b0, manual_mode_i = 1'b0;
  logic [1:0] rate_sel_i = 2'd0;
  logic arm_i = 1'b0, abort_i = 1'b0;
  logic sweep_gate_o, discharge_o, trig_en_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit mon_en = 0;
  int exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  sweep_seq #(.HOLD_BASE(HB), .HOLD_EXT0(HE0), .HOLD_EXT1(HE1)) uut (
    .clk(clk), .rst_n(rst_n), .sweep_end_i(sweep_end_i), .trig_i(trig_i),
    .single_mode_i(single_mode_i), .manual_mode_i(manual_mode_i),
    .rate_sel_i(rate_sel_i), .arm_i(arm_i), .abort_i(abort_i),
    .sweep_gate_o(sweep_gate_o), .discharge_o(discharge_o), .trig_en_o(trig_en_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  // expected holdoff, computed from the requirement text
  function automatic int hold_len(input logic [1:0] s);
    return HB + (s[0] ? HE0 : 0) + (s[1] ? HE1 : 0);
  endfunction

  task automatic expect_hold(input logic [1:0] s);
    exp_q.push_back(hold_len(s));
    mon_en = 1;
  endtask

  task automatic pulse_trig(output logic g);
    trig_i = 1'b1; tick(3); g = sweep_gate_o;
    trig_i = 1'b0; tick(3);
  endtask

  task automatic pulse_end();
    sweep_end_i = 1'b1; tick(3);
    sweep_end_i = 1'b0; tick(3);
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (!trig_en_o && n < 500) begin tick(); n++; end
    chk(req, trig_en_o, 1);
    mon_en = 0;
  endtask

  // monitor: measures holdoff length and compares against the queue
  initial begin
    bit prev_dis = 1'b1;
    bit counting = 1'b0;
    int cnt = 0;
    forever begin
      @(posedge clk);
      #3;
      if (counting) begin
        cnt++;
        if (trig_en_o) begin
          counting = 1'b0;
          if (exp_q.size() == 0) chk("R4 unexpected holdoff", cnt, -1);
          else chk("R4 holdoff length", cnt, exp_q.pop_front());
        end
      end else if (mon_en && discharge_o && !prev_dis) begin
        counting = 1'b1;
        cnt = 0;
      end
      prev_dis = discharge_o;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic g;
    tick(4);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 gate", sweep_gate_o, 0);
    chk("R1 discharge", discharge_o, 1);
    chk("R1 trig_en", trig_en_o, 1);

    // R2 start latency
    trig_i = 1'b1; tick(2);
    chk("R2 gate before 3rd edge", sweep_gate_o, 0);
    tick(1);
    chk("R2 gate", sweep_gate_o, 1);
    chk("R2 discharge", discharge_o, 0);
    chk("R2 trig_en", trig_en_o, 0);
    trig_i = 1'b0; tick(3);

    // R3 + R4 base holdoff
    expect_hold(2'd0);
    sweep_end_i = 1'b1; tick(3);
    chk("R3 gate", sweep_gate_o, 0);
    chk("R3 discharge", discharge_o, 1);
    sweep_end_i = 1'b0;
    wait_ready("R3 ready after holdoff");

    // R4 + R5 selection 1 with triggers during holdoff
    rate_sel_i = 2'd1;
    pulse_trig(g); chk("R2 restart", g, 1);
    expect_hold(2'd1);
    pulse_end();
    pulse_trig(g); chk("R5 trig in holdoff", g, 0);
    wait_ready("R5 ready");
    tick(5);
    chk("R5 no late start", sweep_gate_o, 0);

    // R4 selections 2 and 3
    for (int s = 2; s < 4; s++) begin
      rate_sel_i = 2'(s);
      pulse_trig(g); chk("R4 start", g, 1);
      expect_hold(2'(s));
      pulse_end();
      wait_ready("R4 ready");
    end
    rate_sel_i = 2'd0;

    // R6 held trigger
    trig_i = 1'b1; tick(3);
    chk("R6 first start", sweep_gate_o, 1);
    pulse_end();
    wait_ready("R6 ready");
    tick(6);
    chk("R6 held trig no restart", sweep_gate_o, 0);
    trig_i = 1'b0; tick(3);

    // R12 end edge while waiting
    pulse_end();
    chk("R12 gate", sweep_gate_o, 0);
    chk("R12 trig_en", trig_en_o, 1);

    // R7 single-sweep arming
    single_mode_i = 1'b1; #1;
    chk("R7 trig_en unarmed", trig_en_o, 0);
    pulse_trig(g); chk("R7 trig ignored unarmed", g, 0);
    arm_i = 1'b1; tick(1); arm_i = 1'b0;
    chk("R7 trig_en after arm", trig_en_o, 1);
    pulse_trig(g); chk("R7 armed start", g, 1);
    // R8 arm consumed
    pulse_end();
    tick(HB + 10);
    chk("R8 trig_en after holdoff", trig_en_o, 0);
    chk("R8 discharge", discharge_o, 1);
    pulse_trig(g); chk("R8 trig ignored", g, 0);
    arm_i = 1'b1; tick(1); arm_i = 1'b0;
    chk("R8 rearm", trig_en_o, 1);
    single_mode_i = 1'b0;
    tick(1);

    // R9 abort during sweep
    pulse_trig(g); chk("R9 start", g, 1);
    expect_hold(2'd0);
    abort_i = 1'b1; tick(1); abort_i = 1'b0;
    chk("R9 gate", sweep_gate_o, 0);
    chk("R9 discharge", discharge_o, 1);
    wait_ready("R9 ready");

    // R10 abort same edge as trigger event
    trig_i = 1'b1; tick(2);
    abort_i = 1'b1; tick(1); abort_i = 1'b0;
    chk("R10 gate", sweep_gate_o, 0);
    chk("R10 trig_en", trig_en_o, 0);
    wait_ready("R10 ready");
    tick(3);
    chk("R10 no sweep", sweep_gate_o, 0);
    trig_i = 1'b0; tick(3);

    // R11 manual mode
    manual_mode_i = 1'b1; #1;
    chk("R11 gate", sweep_gate_o, 1);
    chk("R11 discharge", discharge_o, 0);
    chk("R11 trig_en", trig_en_o, 0);
    pulse_end();
    chk("R11 gate after end", sweep_gate_o, 1);
    expect_hold(2'd0);
    manual_mode_i = 1'b0; #1;
    chk("R11 gate released", sweep_gate_o, 0);
    wait_ready("R11 ready");
    tick(3);

    chk("R4 queue drained", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule